// File: doc/BRIEF.md
# Ordered Posted-Write Bus Arbiter

This block sits between a processor core's request port and one external bus. Memory writes, and the I/O writes of a repeated string output, are posted into a small in-order buffer so the core can run ahead. Every other request is held as a single pending operation that stalls the core until its bus cycle completes. The buffer drains in the background whenever the bus is free.

Ordering is kept in these ways. An I/O read, a single I/O write and a locked read wait until the buffer is empty. An ordinary memory read may overtake buffered writes only if none of them targets its address. A locked read-modify-write pair holds the LOCK output from the locked read until its write-back completes, and no other cycle may come between the two halves.

The bus side uses a valid/ready request handshake and a one-cycle done pulse that completes the cycle. Only one bus cycle is outstanding at a time.

Top module: `owb_arbiter`

## Requirements
- R1: A posted request is a non-locked write that is either to memory (`req_io`=0) or marked string I/O (`req_str`=1). It is accepted with `core_stall` low while the buffer holds fewer than DEPTH (4) entries. When the buffer is full, `core_stall` stays high until an entry retires.
- R2: Buffered writes reach the bus once each, in acceptance order, with their own address, data and I/O flag.
- R3: An I/O read (`req_io`=1, `req_write`=0) is placed on the bus only when no buffered write remains.
- R4: A single I/O write (I/O, write, `req_str`=0, not locked) is never buffered. It waits for an empty buffer, and the core stays stalled until that cycle's done pulse. A read that follows it therefore starts only afterwards.
- R5: An ordinary memory read whose address matches no buffered memory write is issued ahead of the remaining buffered writes.
- R6: A memory read whose address matches a buffered memory write is issued only when no matching entry is left.
- R7: A locked read (`req_lock`=1, read) is issued only with the buffer empty, and `bus_lock` is high when it is issued.
- R8: `bus_lock` stays high from the locked read until the done pulse of the following locked write, then drops. No other bus cycle is placed between the two halves.
- R9: `bus_nocache` is 1 for every locked read. For other non-buffered cycles it equals `req_nc`. For buffered writes it is 0.
- R10: `bus_valid` is never high while a bus cycle awaits its done pulse.
- R11: A non-buffered request completes in the cycle after its done pulse. In that cycle `rsp_valid` is 1, `core_stall` is 0 and, for reads, `rsp_rdata` holds the bus read data.
- R12: During and after reset, `bus_valid`, `bus_lock` and `rsp_valid` are 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present, held while stalled |
| req_write | input | 1 | 1 = write |
| req_io | input | 1 | 1 = I/O space |
| req_str | input | 1 | I/O write belongs to a repeated string output |
| req_lock | input | 1 | Part of a locked read-modify-write pair |
| req_nc | input | 1 | Non-cacheable access |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| core_stall | output | 1 | Core must hold its request |
| rsp_valid | output | 1 | Non-buffered request completes this cycle |
| rsp_rdata | output | DW | Read data for a completing read |
| bus_valid | output | 1 | Bus cycle request |
| bus_ready | input | 1 | Bus accepts the request |
| bus_write | output | 1 | Bus cycle is a write |
| bus_io | output | 1 | Bus cycle is in I/O space |
| bus_nocache | output | 1 | Data must come from external memory, not cached |
| bus_lock | output | 1 | Bus locked for an atomic pair |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_done | input | 1 | Outstanding bus cycle finished |
| bus_rdata | input | DW | Read data, valid with bus_done |

## Verification
Two functions can coincide in one cycle. The first is a buffered entry retiring on its done pulse while the core presents a new posted write to a full buffer. The second is a waiting memory read being chosen in the same edge in which the last matching buffered write retires. The bench provokes both by slowing the bus so that the buffer fills and reads arrive behind queued writes. Its behavioural model judges them by comparing the stall level against the queue size before that cycle's retirement, and by checking that a read becomes eligible only once its match has left the queue.

// File: rtl/owb_pkg.sv
package owb_pkg;
  typedef enum logic [1:0] {E_IDLE, E_REQ, E_WAIT} eng_e;
  typedef enum logic [1:0] {SRC_NONE, SRC_OP, SRC_BUF} src_e;
  typedef enum logic [2:0] {K_MRD, K_IORD, K_IOWR, K_LRD, K_LWR} op_kind_e;
endpackage

// File: rtl/owb_post_fifo.sv
module owb_post_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_io_i,
  input  logic          pop_i,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  output logic          head_io_o,
  output logic          full_o,
  output logic          empty_o,
  input  logic [AW-1:0] match_addr_i,
  output logic          hit_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] tag [DEPTH];
  logic [DEPTH-1:0] vld, isio, hitv;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [PW:0]   cnt;

  // data storage: plain write port, no reset, RAM-inferable
  always_ff @(posedge clk) begin
    if (push_i) begin
      mem[wr_ptr] <= push_data_i;
      tag[wr_ptr] <= push_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      vld    <= '0;
      isio   <= '0;
    end else begin
      if (push_i) begin
        vld[wr_ptr]  <= 1'b1;
        isio[wr_ptr] <= push_io_i;
        wr_ptr       <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      end
      if (pop_i) begin
        vld[rd_ptr] <= 1'b0;
        rd_ptr      <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      cnt <= cnt + (PW+1)'(push_i) - (PW+1)'(pop_i);
    end
  end

  // address match against every live memory entry
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitv[g] = vld[g] && !isio[g] && (tag[g] == match_addr_i);
  end

  assign hit_o       = |hitv;
  assign head_addr_o = tag[rd_ptr];
  assign head_data_o = mem[rd_ptr];
  assign head_io_o   = isio[rd_ptr];
  assign full_o      = (cnt == FULL_CNT);
  assign empty_o     = (cnt == '0);

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/owb_core_if.sv
module owb_core_if
  import owb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_str,
  input  logic          req_lock,
  input  logic          req_nc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          buf_full_i,
  input  logic          op_done_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          stall_o,
  output logic          push_o,
  output logic          op_busy_o,
  output op_kind_e      op_kind_o,
  output logic [AW-1:0] op_addr_o,
  output logic [DW-1:0] op_wdata_o,
  output logic          op_nc_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o
);
  logic posted, capture, op_fin;
  op_kind_e kind_nx;

  assign posted  = req_write && !req_lock && (!req_io || req_str);
  assign capture = req_valid && !posted && !op_busy_o && !op_fin;
  assign push_o  = req_valid && posted && !buf_full_i;
  assign stall_o = req_valid && (posted ? buf_full_i : !op_fin);
  assign rsp_valid_o = op_fin;

  always_comb begin
    if (req_lock)    kind_nx = req_write ? K_LWR : K_LRD;
    else if (req_io) kind_nx = req_write ? K_IOWR : K_IORD;
    else             kind_nx = K_MRD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_busy_o   <= 1'b0;
      op_fin      <= 1'b0;
      op_kind_o   <= K_MRD;
      op_addr_o   <= '0;
      op_wdata_o  <= '0;
      op_nc_o     <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      op_fin <= op_done_i;
      if (op_done_i) begin
        op_busy_o   <= 1'b0;
        rsp_rdata_o <= bus_rdata_i;
      end else if (capture) begin
        op_busy_o  <= 1'b1;
        op_kind_o  <= kind_nx;
        op_addr_o  <= req_addr;
        op_wdata_o <= req_wdata;
        op_nc_o    <= req_nc || (req_lock && !req_write);
      end
    end
  end

  a_r4_single_io_write_unbuffered: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_io && !req_str) |-> !push_o);
endmodule

// File: rtl/owb_arbiter.sv
module owb_arbiter
  import owb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 16,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_str,
  input  logic          req_lock,
  input  logic          req_nc,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          core_stall,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic          bus_io,
  output logic          bus_nocache,
  output logic          bus_lock,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_done,
  input  logic [DW-1:0] bus_rdata
);
  logic push, pop, full, empty, hit, op_busy, op_done, op_nc, op_go, hd_io, lwr_q;
  logic [AW-1:0] op_addr, hd_addr;
  logic [DW-1:0] op_wdata, hd_data;
  op_kind_e op_kind;
  eng_e     state;
  src_e     src_q;

  owb_post_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push), .push_addr_i(req_addr),
    .push_data_i(req_wdata), .push_io_i(req_io), .pop_i(pop),
    .head_addr_o(hd_addr), .head_data_o(hd_data), .head_io_o(hd_io),
    .full_o(full), .empty_o(empty), .match_addr_i(op_addr), .hit_o(hit));

  owb_core_if #(.AW(AW), .DW(DW)) u_core (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_str(req_str), .req_lock(req_lock), .req_nc(req_nc),
    .req_addr(req_addr), .req_wdata(req_wdata), .buf_full_i(full),
    .op_done_i(op_done), .bus_rdata_i(bus_rdata), .stall_o(core_stall),
    .push_o(push), .op_busy_o(op_busy), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_wdata_o(op_wdata), .op_nc_o(op_nc),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata));

  // ordering gate for the pending non-buffered operation
  always_comb begin
    unique case (op_kind)
      K_MRD:   op_go = !hit;
      K_LWR:   op_go = 1'b1;
      default: op_go = empty;
    endcase
  end

  assign pop     = (state == E_WAIT) && bus_done && (src_q == SRC_BUF);
  assign op_done = (state == E_WAIT) && bus_done && (src_q == SRC_OP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= E_IDLE;
      src_q       <= SRC_NONE;
      bus_valid   <= 1'b0;
      bus_write   <= 1'b0;
      bus_io      <= 1'b0;
      bus_nocache <= 1'b0;
      bus_lock    <= 1'b0;
      bus_addr    <= '0;
      bus_wdata   <= '0;
      lwr_q       <= 1'b0;
    end else begin
      unique case (state)
        E_IDLE: begin
          if (op_busy && op_go) begin
            state       <= E_REQ;
            src_q       <= SRC_OP;
            bus_valid   <= 1'b1;
            bus_write   <= (op_kind == K_IOWR) || (op_kind == K_LWR);
            bus_io      <= (op_kind == K_IOWR) || (op_kind == K_IORD);
            bus_nocache <= op_nc;
            bus_addr    <= op_addr;
            bus_wdata   <= op_wdata;
            lwr_q       <= (op_kind == K_LWR);
            if (op_kind == K_LRD) bus_lock <= 1'b1;
          end else if (!bus_lock && !empty) begin
            state       <= E_REQ;
            src_q       <= SRC_BUF;
            bus_valid   <= 1'b1;
            bus_write   <= 1'b1;
            bus_io      <= hd_io;
            bus_nocache <= 1'b0;
            bus_addr    <= hd_addr;
            bus_wdata   <= hd_data;
            lwr_q       <= 1'b0;
          end
        end
        E_REQ: begin
          if (bus_ready) begin
            bus_valid <= 1'b0;
            state     <= E_WAIT;
          end
        end
        E_WAIT: begin
          if (bus_done) begin
            state <= E_IDLE;
            src_q <= SRC_NONE;
            if (src_q == SRC_OP && lwr_q) bus_lock <= 1'b0;
          end
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  a_r3_io_read_after_drain: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_io && !bus_write) |-> empty);
  a_r7_lock_on_empty: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_lock) |-> empty);
  a_r8_lock_drops_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_lock) |-> $past(bus_done));
  a_r10_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr)));
endmodule

// File: tb/owb_arbiter_bench.sv
module owb_arbiter_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int K_MRD = 0, K_IORD = 1, K_IOWR = 2, K_LRD = 3, K_LWR = 4;

  typedef struct packed {
    logic wr, io, str, lk, nc, slow;
    logic [15:0] addr, data;
    logic [3:0] gap;
  } rq_t;
  typedef struct packed { logic [15:0] a, d; logic io; } ent_t;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0, req_io = 0, req_str = 0, req_lock = 0, req_nc = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic core_stall, rsp_valid, bus_valid, bus_write, bus_io, bus_nocache, bus_lock;
  logic [DW-1:0] rsp_rdata, bus_wdata;
  logic [AW-1:0] bus_addr;
  logic bus_ready = 0, bus_done = 0;
  logic [DW-1:0] bus_rdata = '0;

  owb_arbiter #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_owb_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_str(req_str), .req_lock(req_lock), .req_nc(req_nc),
    .req_addr(req_addr), .req_wdata(req_wdata), .core_stall(core_stall),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_io(bus_io),
    .bus_nocache(bus_nocache), .bus_lock(bus_lock), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_rdata(bus_rdata));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  rq_t prog[$];
  ent_t mq[$];

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic add(input logic wr, io, str, lk, nc, slow, input logic [15:0] a, d, input int gap);
    rq_t r;
    r = '{wr: wr, io: io, str: str, lk: lk, nc: nc, slow: slow, addr: a, data: d, gap: 4'(gap)};
    prog.push_back(r);
  endtask

  function automatic logic [15:0] rdf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  function automatic bit qmatch(input logic [15:0] a);
    foreach (mq[i]) if (!mq[i].io && mq[i].a == a) return 1'b1;
    return 1'b0;
  endfunction

  // model state
  bit op_pend = 0, fin_exp = 0, fin_next = 0, m_lock = 0, outst = 0, out_op = 0, prev_v = 0;
  int op_kind = 0, op_age = 0, rise_age = 0, rcnt = 0, cyc = 0, bypass_seen = 0;
  logic [15:0] op_a = '0, op_d = '0, out_a = '0, exp_rd = '0;
  bit op_nc = 0, slow = 0;
  rq_t cur;
  bit cur_act = 0;
  int gap_cnt = 0, idx = 0;

  initial begin
    // A: bypass, matching read, I/O read
    add(1,0,0,0,0,0,16'h0100,16'h1111,0); add(1,0,0,0,0,0,16'h0104,16'h2222,0);
    add(1,0,0,0,0,0,16'h0108,16'h3333,0); add(0,0,0,0,0,0,16'h0200,16'h0,0);
    add(0,0,0,0,0,0,16'h0104,16'h0,1);    add(1,0,0,0,0,0,16'h010C,16'h4444,0);
    add(0,1,0,0,0,0,16'h0010,16'h0,2);
    // B: single I/O write then non-cacheable read
    add(1,0,0,0,0,0,16'h0300,16'h5555,0); add(1,0,0,0,0,0,16'h0304,16'h6666,0);
    add(1,1,0,0,0,0,16'h0020,16'h7777,0); add(0,0,0,0,1,0,16'h0400,16'h0,2);
    // C: string I/O writes are posted
    add(1,1,1,0,0,0,16'h0030,16'h8881,0); add(1,1,1,0,0,0,16'h0030,16'h8882,0);
    add(1,1,1,0,0,0,16'h0030,16'h8883,0); add(1,0,0,0,0,0,16'h0500,16'h9999,3);
    // D: slow bus, buffer fills, then matching read
    for (int i = 0; i < 7; i++) add(1,0,0,0,0,1,16'h0600 + 16'(4*i),16'hA000 + 16'(i),0);
    add(0,0,0,0,0,1,16'h0604,16'h0,2);
    // E: locked pair behind pending writes
    add(1,0,0,0,0,0,16'h0700,16'hB001,0); add(1,0,0,0,0,0,16'h0704,16'hB002,0);
    add(0,0,0,1,0,0,16'h0800,16'h0,0);    add(1,0,0,1,0,0,16'h0800,16'hC0DE,0);
    add(1,0,0,0,0,0,16'h0708,16'hB003,0); add(0,0,0,0,0,0,16'h0900,16'h0,0);
    add(0,1,0,0,0,0,16'h0040,16'h0,0);

    // R12: reset state
    repeat (3) begin
      @(negedge clk); #1;
      chk(bus_valid == 0, "R12 bus_valid", 32'(bus_valid), 0);
      chk(bus_lock == 0, "R12 bus_lock", 32'(bus_lock), 0);
      chk(rsp_valid == 0, "R12 rsp_valid", 32'(rsp_valid), 0);
      chk(core_stall == 0, "R12 core_stall", 32'(core_stall), 0);
    end
    rst = 0;

    forever begin
      @(negedge clk);
      cyc++;
      // bus responder
      bus_done  = outst && rcnt == 0;
      bus_rdata = bus_done ? rdf(out_a) : '0;
      bus_ready = slow ? (cyc % 4 == 3) : (cyc % 3 != 1);
      // core driver
      if (!cur_act) begin
        req_valid = 0;
        if (gap_cnt > 0) gap_cnt--;
        else if (idx < prog.size()) begin
          cur = prog[idx]; idx++; cur_act = 1; slow = cur.slow;
          req_valid = 1; req_write = cur.wr; req_io = cur.io; req_str = cur.str;
          req_lock = cur.lk; req_nc = cur.nc; req_addr = cur.addr; req_wdata = cur.data;
        end
      end
      #1;
      if (op_pend) op_age++;
      if (bus_valid && !prev_v) rise_age = op_pend ? op_age : 0;
      prev_v = bus_valid;

      chk(rsp_valid == fin_exp, "R11 rsp_valid", 32'(rsp_valid), 32'(fin_exp));
      if (fin_exp && (op_kind != K_IOWR) && (op_kind != K_LWR))
        chk(rsp_rdata == exp_rd, "R11 rsp_rdata", 32'(rsp_rdata), 32'(exp_rd));
      if (!bus_valid) chk(bus_lock == m_lock, "R8 lock level", 32'(bus_lock), 32'(m_lock));
      if (bus_valid) chk(!outst, "R10 valid while outstanding", 32'(outst), 0);

      if (req_valid) begin
        if (req_write && !req_lock && (!req_io || req_str)) begin
          chk(core_stall == (mq.size() == DEPTH), "R1 posted stall", 32'(core_stall), 32'(mq.size() == DEPTH));
          if (!core_stall) begin
            mq.push_back('{a: req_addr, d: req_wdata, io: req_io});
            cur_act = 0; gap_cnt = cur.gap;
          end
        end else begin
          chk(core_stall == !fin_exp, "R4 stall until done", 32'(core_stall), 32'(!fin_exp));
          if (fin_exp) begin
            cur_act = 0; gap_cnt = cur.gap;
          end else if (!op_pend) begin
            op_pend = 1; op_age = 0; op_a = req_addr; op_d = req_wdata;
            op_nc = req_nc || (req_lock && !req_write);
            op_kind = req_lock ? (req_write ? K_LWR : K_LRD) : req_io ? (req_write ? K_IOWR : K_IORD) : K_MRD;
          end
        end
      end else chk(core_stall == 0, "R1 idle stall", 32'(core_stall), 0);

      fin_exp = 0;
      if (bus_done) begin
        if (!out_op) void'(mq.pop_front());
        else begin
          exp_rd = rdf(out_a);
          if (op_kind == K_LWR) m_lock = 0;
          fin_next = 1; op_pend = 0;
        end
        outst = 0;
      end else if (outst && rcnt > 0) rcnt--;

      if (bus_valid && bus_ready) begin
        if (bus_write && !bus_lock && mq.size() > 0) begin
          chk(!m_lock, "R8 cycle inside locked pair", 32'(m_lock), 0);
          chk(bus_addr == mq[0].a && bus_wdata == mq[0].d && bus_io == mq[0].io,
              "R2 buffered order", {bus_addr, bus_wdata}, {mq[0].a, mq[0].d});
          chk(bus_nocache == 0, "R9 buffered nocache", 32'(bus_nocache), 0);
          if (op_pend && op_kind == K_MRD && rise_age >= 2)
            chk(qmatch(op_a), "R5 read not bypassing", 32'(op_a), 0);
          out_op = 0;
        end else begin
          chk(op_pend, "R2 unexpected bus cycle", {bus_addr, bus_wdata}, 0);
          chk(bus_addr == op_a, "R2 op address", 32'(bus_addr), 32'(op_a));
          chk(bus_write == (op_kind == K_IOWR || op_kind == K_LWR), "R2 op dir", 32'(bus_write), 32'(op_kind));
          chk(bus_io == (op_kind == K_IOWR || op_kind == K_IORD), "R2 op space", 32'(bus_io), 32'(op_kind));
          if (bus_write) chk(bus_wdata == op_d, "R2 op data", 32'(bus_wdata), 32'(op_d));
          chk(bus_nocache == op_nc, "R9 nocache", 32'(bus_nocache), 32'(op_nc));
          if (m_lock) chk(op_kind == K_LWR, "R8 cycle inside locked pair", 32'(op_kind), K_LWR);
          case (op_kind)
            K_IORD: chk(mq.size() == 0, "R3 I/O read before drain", 32'(mq.size()), 0);
            K_IOWR: chk(mq.size() == 0, "R4 I/O write before drain", 32'(mq.size()), 0);
            K_LRD: begin
              chk(mq.size() == 0, "R7 locked read before drain", 32'(mq.size()), 0);
              chk(bus_lock == 1, "R7 lock with read", 32'(bus_lock), 1);
              chk(bus_nocache == 1, "R9 locked read nocache", 32'(bus_nocache), 1);
              m_lock = 1;
            end
            K_LWR: chk(bus_lock == 1 && m_lock, "R8 lock across write", 32'(bus_lock), 1);
            default: begin
              chk(!qmatch(op_a), "R6 read passed matching write", 32'(op_a), 0);
              if (mq.size() > 0) bypass_seen++;
            end
          endcase
          out_op = 1;
        end
        outst = 1; out_a = bus_addr;
        rcnt = slow ? 6 : (cyc % 3);
      end
      fin_exp = fin_next; fin_next = 0;

      if (idx == prog.size() && !cur_act && gap_cnt == 0 && mq.size() == 0 &&
          !outst && !op_pend && !fin_exp && !bus_valid) begin
        chk(bypass_seen > 0, "R5 bypass observed", 32'(bypass_seen), 1);
        chk(bus_lock == 0, "R8 lock released", 32'(bus_lock), 0);
        break;
      end
      if (cyc > 20000) begin
        chk(0, "watchdog", 32'(cyc), 0);
        break;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule